// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the word address for each beat of a fixed-length burst in a synchronous burst memory. When a new read or write command is accepted, it captures the full starting address. Each later continue command moves the burst one beat forward. Only the low beat-select bits change during a burst. They are formed from the captured start bits and a beat counter, in one of two orders. In interleaved order the beat bits are the start bits XOR the counter. In linear order they are the start bits plus the counter, wrapping inside the aligned block. With the default parameters a burst is four beats on the two low address bits.

A clock-enable input gates every state change. While it is low, an edge does nothing and the address and counter hold. The order select is sampled together with the start address, so one burst keeps a single order from start to end. A last-beat flag marks the final beat of the block. A continue command after that beat wraps back to the starting beat. A continue command that arrives before any burst has started has no effect.

Top module: `burst_addr_seq`

## Requirements
- R1: On a clock edge with `ce` high and `cmd_start` high, `beat_addr` becomes `start_addr` and `last_beat` goes low.
- R2: If `order_sel` was 1 when the burst started, then on beat k (k = 0..3) the low two bits of `beat_addr` equal the start's low two bits XOR k.
- R3: If `order_sel` was 0 when the burst started, then on beat k the low two bits of `beat_addr` equal (start low bits + k) mod 4.
- R4: An edge with `ce` high, `cmd_advance` high and `cmd_start` low, during an active burst, moves to the next beat. When `cmd_start` and `cmd_advance` are both high, `cmd_start` wins and a new burst is loaded.
- R5: An edge with `ce` low changes neither `beat_addr` nor `last_beat`, whatever the other inputs are.
- R6: The bits of `beat_addr` above the low two stay equal to those of the start address for the whole burst.
- R7: A continue command on the fourth beat returns `beat_addr` to the start address. The address never leaves the aligned four-word block.
- R8: `last_beat` is high exactly when a burst is active and the beat counter equals 3.
- R9: After reset, `beat_addr` is 0 and `last_beat` is 0. Continue commands issued before the first start command have no effect.
- R10: A change of `order_sel` in the middle of a burst does not change the order that burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; when low, the edge is ignored |
| cmd_start | input | 1 | Begin a new burst at `start_addr` |
| cmd_advance | input | 1 | Continue the current burst by one beat |
| order_sel | input | 1 | Beat order: 1 = interleaved (XOR), 0 = linear (add) |
| start_addr | input | ADDR_W | Starting word address of a new burst |
| beat_addr | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High on the final beat of the block |

## Verification
The corner that is hardest to reach from the ports is a continue command on the fourth beat. To get there, a start must be followed by exactly three accepted continues with no intervening start. If any enable-low cycle falls in that run, it must not count as a beat. The directed part of the stimulus builds this run for every start offset in both orders. It also places enable-low cycles and a mid-burst change of order select inside the run. The random part then uses a low start probability, so long continue runs that wrap several times occur often.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } beat_order_e;

   localparam int unsigned DEF_ADDR_W = 18;
   localparam int unsigned DEF_BEAT_W = 2;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] cnt,
   output logic              active
);
   logic [BEAT_W-1:0] cnt_q;
   logic              act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (load) begin
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (step && act_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt    = cnt_q;
   assign active = act_q;
endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load,
   input  logic [ADDR_W-1:0]                   addr_d,
   input  burst_addr_seq_pkg::beat_order_e     mode_d,
   output logic [ADDR_W-1:0]                   addr_q,
   output burst_addr_seq_pkg::beat_order_e     mode_q
);
   import burst_addr_seq_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= ORD_LINEAR;
      end else if (load) begin
         addr_q <= addr_d;
         mode_q <= mode_d;
      end
   end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic [BEAT_W-1:0]               base_lo,
   input  logic [BEAT_W-1:0]               beat,
   input  burst_addr_seq_pkg::beat_order_e mode,
   output logic [BEAT_W-1:0]               lo_out
);
   import burst_addr_seq_pkg::*;

   logic [BEAT_W-1:0] xor_bits;
   logic [BEAT_W-1:0] sum_bits;
   logic [BEAT_W-1:0] carry;

   assign carry[0] = 1'b0;

   for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
      assign xor_bits[i] = base_lo[i] ^ beat[i];
      assign sum_bits[i] = base_lo[i] ^ beat[i] ^ carry[i];
      if (i < BEAT_W - 1) begin : g_carry
         assign carry[i+1] = (base_lo[i] & beat[i]) |
                             (carry[i] & (base_lo[i] ^ beat[i]));
      end
   end

   assign lo_out = (mode == ORD_INTERLEAVE) ? xor_bits : sum_bits;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_addr_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned BEAT_W = DEF_BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              cmd_start,
   input  logic              cmd_advance,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              last_beat
);
   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1) begin : g_bad_beat
      $error("burst_addr_seq: BEAT_W must be at least 1");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
   end

   logic              load_en;
   logic              step_en;
   logic [BEAT_W-1:0] beat_cnt;
   logic              burst_act;
   logic [ADDR_W-1:0] base_q;
   beat_order_e       mode_q;
   beat_order_e       mode_d;
   logic [BEAT_W-1:0] lo_addr;

   assign mode_d  = order_sel ? ORD_INTERLEAVE : ORD_LINEAR;
   assign load_en = ce & cmd_start;
   assign step_en = ce & cmd_advance & ~cmd_start;

   bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_en),
      .addr_d (start_addr),
      .mode_d (mode_d),
      .addr_q (base_q),
      .mode_q (mode_q)
   );

   bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_en),
      .step   (step_en),
      .cnt    (beat_cnt),
      .active (burst_act)
   );

   bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
      .base_lo (base_q[BEAT_W-1:0]),
      .beat    (beat_cnt),
      .mode    (mode_q),
      .lo_out  (lo_addr)
   );

   assign beat_addr = {base_q[ADDR_W-1 -: HI_W], lo_addr};
   assign last_beat = burst_act & (&beat_cnt);
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic              cmd_start,
   input logic              cmd_advance,
   input logic [ADDR_W-1:0] start_addr,
   input logic [ADDR_W-1:0] beat_addr,
   input logic              last_beat,
   input logic [ADDR_W-1:0] base_q
);
   logic seen_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen_start <= 1'b0;
      else if (ce && cmd_start)  seen_start <= 1'b1;
   end

   // R1
   p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && cmd_start) |=> (beat_addr == $past(start_addr)) && !last_beat);

   // R5
   p_hold_on_ce_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(beat_addr) && $stable(last_beat));

   // R6
   p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !cmd_start) |=> $stable(beat_addr[ADDR_W-1:BEAT_W]));

   // R7
   p_wrap_to_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && cmd_advance && !cmd_start && last_beat) |=> (beat_addr == base_q) && !last_beat);

   // R9
   p_idle_advance_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_start && !(ce && cmd_start)) |=> (beat_addr == '0) && !last_beat);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce          (ce),
   .cmd_start   (cmd_start),
   .cmd_advance (cmd_advance),
   .start_addr  (start_addr),
   .beat_addr   (beat_addr),
   .last_beat   (last_beat),
   .base_q      (base_q)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce = 1'b0;
   logic          cmd_start = 1'b0;
   logic          cmd_advance = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] beat_addr;
   logic          last_beat;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [AW-1:0] rb;
   logic [1:0]    rc;
   logic          rm;
   logic          ra;

   always #10 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .ce(ce), .cmd_start(cmd_start),
      .cmd_advance(cmd_advance), .order_sel(order_sel),
      .start_addr(start_addr), .beat_addr(beat_addr), .last_beat(last_beat)
   );

   function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] c, logic m);
      logic [1:0] lo;
      lo = m ? (b[1:0] ^ c) : (b[1:0] + c);
      return {b[AW-1:2], lo};
   endfunction

   function automatic logic exp_last(logic a, logic [1:0] c);
      return a && (c == 2'd3);
   endfunction

   task automatic check(string tag);
      logic [AW-1:0] ea;
      logic          el;
      ea = exp_addr(rb, rc, rm);
      el = exp_last(ra, rc);
      n_tests++;
      if (beat_addr !== ea || last_beat !== el) begin
         n_fail++;
         $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                  tag, beat_addr, last_beat, ea, el);
      end
   endtask

   // check the state left by the previous edge, then drive the next inputs
   task automatic cyc(input logic c, input logic s, input logic a,
                      input logic m, input logic [AW-1:0] ad, input string tag);
      @(negedge clk);
      check(tag);
      ce = c; cmd_start = s; cmd_advance = a; order_sel = m; start_addr = ad;
      if (c) begin
         if (s) begin rb = ad; rm = m; rc = 2'd0; ra = 1'b1; end
         else if (a && ra) rc = rc + 2'd1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      rb = '0; rc = '0; rm = 1'b0; ra = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 reset");
      @(negedge clk);
      rst_n = 1'b1;
      // R9: advances before any start change nothing
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, i[0], 18'h2AAAA, "R9 advance before start");
      // R2 / R3 / R7 / R8: every start offset, both orders, wrap twice
      for (int m = 0; m < 2; m++) begin
         for (int o = 0; o < 4; o++) begin
            logic [AW-1:0] sa;
            sa = {16'hA5C3 + 16'(o * 7 + m), 2'(o)};
            cyc(1, 1, 0, m[0], sa, "R1 start");
            for (int k = 0; k < 9; k++)
               cyc(1, 0, 1, m[0], ~sa, m ? "R2 interleave/R7/R8" : "R3 linear/R7/R8");
         end
      end
      // R5: ce low with start and advance asserted in the middle of a burst
      cyc(1, 1, 0, 0, 18'h1F002, "R1 start");
      cyc(1, 0, 1, 0, 18'h0, "R4 advance");
      for (int i = 0; i < 4; i++) cyc(0, i[0], 1, 1, 18'h3FFFF, "R5 ce low hold");
      cyc(1, 0, 1, 0, 18'h0, "R5 after hold");
      cyc(1, 0, 1, 0, 18'h0, "R6 upper fixed");
      // R4: start and advance together, start wins
      cyc(1, 1, 1, 1, 18'h0BEE1, "R4 start priority");
      cyc(1, 0, 1, 1, 18'h0, "R4 after priority");
      // R10: order select toggled mid-burst
      cyc(1, 1, 0, 1, 18'h12343, "R10 start interleave");
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 18'h0, "R10 mode change ignored");
      cyc(1, 1, 0, 0, 18'h12343, "R10 start linear");
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 18'h0, "R10 mode change ignored");
      // random phase
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 10) < 8, ($urandom % 100) < 12, ($urandom % 10) < 7,
             $urandom % 2, AW'($urandom), "random R2/R3/R4/R5/R7/R8");
      end
      @(negedge clk);
      check("final");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule